// File: doc/BRIEF.md
# Indexed Shadow Control Register Bank

This block holds the byte-wide control registers of a four-channel data converter. A simple parallel register bus drives it: an 8-bit address, 8-bit write data, a write strobe and a read strobe. Read data comes back registered one cycle after the read strobe. Global registers take effect at once. These are the port configuration register and the channel-select register.

Per-channel registers use two copies. A write lands in the master copy of every channel whose enable bit is set in the channel-select register. The outputs are driven from slave copies. Slave copies change only when software writes the transfer command, which copies every master into its slave on the same clock edge. The per-channel registers are the power mode, the duty-cycle stabilizer enable and the test-mode byte. This lets software stage settings for several channels and apply them together.

A soft reset, written through the port configuration register, returns every register to its default. The identifier and grade registers are read-only constants set by parameters.

Top module: `chan_ctrl_bank`

## Requirements
- R1: After reset, reads return 0x18 at 0x00, 0x02 at 0x01, {0,GRADE,0000} at 0x02 (GRADE defaults to 000), 0x0F at 0x05, 0x00 at 0x08, 0x01 at 0x09 and 0x00 at 0x0D. After reset, every channel's outputs show power mode 000, stabilizer enable 1 and test byte 0x00, and lsb_first_o is 0.
- R2: A write to 0x00 with neither bit 5 nor bit 2 set makes LSB-first active when bit 6 or bit 1 is 1. LSB-first then shows on lsb_first_o and 0x00 reads back 0x5A. When both bits are 0, LSB-first is cleared and 0x00 reads back 0x18.
- R3: Addresses 0x01 and 0x02 are read-only, and writes to them leave their read values unchanged.
- R4: A write to 0x05 stores bits [5:0]. Bits [3:0] are the enables for channels A..D (bit n is channel n). Bits [5:4] are the clock-output and frame-output selects. A read of 0x05 returns the stored bits with bits [7:6] as 0.
- R5: A write to a per-channel register changes the masters of the enabled channels only. The per-channel registers are 0x08 bits [2:0] (power mode), 0x09 bit 0 (stabilizer) and 0x0D bits [7:0] (bits [3:0] output test mode, bit 4 short-PN reset, bit 5 long-PN reset, bits [7:6] user test mode). Unused bits read as 0.
- R6: A per-channel output changes only in the cycle after a transfer command or a soft reset, and never directly after a master write.
- R7: A write to 0xFF with bit 0 set copies all masters into their slaves on the same edge. A write to 0xFF with bit 0 clear has no effect, and 0xFF always reads 0x00.
- R8: A read of a per-channel register returns the master value of the lowest-numbered enabled channel, or 0x00 when no channel is enabled.
- R9: A write to 0x00 with bit 5 or bit 2 set returns every master, slave and global register to its R1 default on that edge, so the reset bits read back as 0.
- R10: Reads of unmapped addresses return 0x00, and writes to them change no register or output.
- R11: rdata_o takes the addressed value on the edge where rd_i is sampled high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| lsb_first_o | output | 1 | LSB-first shift order active |
| pwr_mode_o | output | 3*NCH | Active power mode, 3 bits per channel |
| dcs_en_o | output | NCH | Active duty-cycle stabilizer enable per channel |
| test_mode_o | output | 4*NCH | Active output test mode, 4 bits per channel |
| pn_short_rst_o | output | NCH | Active short-PN generator reset per channel |
| pn_long_rst_o | output | NCH | Active long-PN generator reset per channel |
| user_test_o | output | 2*NCH | Active user test mode, 2 bits per channel |

## Verification
The bench stages master writes under many channel masks and then checks that outputs stay put until a transfer. A design that forwarded writes straight to the outputs would fail at once. Sparse masks, including an empty mask, test the lowest-channel readback rule; a design with a reversed priority or stale data from a deselected channel would return the wrong byte. Soft reset is hit through either mirrored bit and after staging. A design that cleared only the slaves would leak old master values through later transfers. Writes with junk in the unused bits, writes to read-only and unmapped addresses, and a transfer write with bit 0 clear all check for stray updates.

// File: rtl/chan_ctrl_bank_pkg.sv
package chan_ctrl_bank_pkg;
  localparam int AW = 8;
  localparam int DW = 8;

  localparam logic [AW-1:0] A_PORT  = 8'h00;
  localparam logic [AW-1:0] A_ID    = 8'h01;
  localparam logic [AW-1:0] A_GRADE = 8'h02;
  localparam logic [AW-1:0] A_INDEX = 8'h05;
  localparam logic [AW-1:0] A_MODE  = 8'h08;
  localparam logic [AW-1:0] A_CLK   = 8'h09;
  localparam logic [AW-1:0] A_TEST  = 8'h0D;
  localparam logic [AW-1:0] A_XFER  = 8'hFF;

  typedef struct packed {
    logic [2:0] pwr;
    logic       dcs;
    logic [7:0] test;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{pwr: 3'b000, dcs: 1'b1, test: 8'h00};

  function automatic logic is_chan_addr(logic [AW-1:0] a);
    return (a == A_MODE) || (a == A_CLK) || (a == A_TEST);
  endfunction
endpackage

// File: rtl/chan_shadow.sv
module chan_shadow
  import chan_ctrl_bank_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          xfer_i,
  output cfg_t          master_o,
  output cfg_t          slave_o
);
  cfg_t m_q, s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= CFG_DEFAULT;
      s_q <= CFG_DEFAULT;
    end else if (srst_i) begin
      m_q <= CFG_DEFAULT;
      s_q <= CFG_DEFAULT;
    end else begin
      if (wr_i) begin
        unique case (addr_i)
          A_MODE:  m_q.pwr  <= wdata_i[2:0];
          A_CLK:   m_q.dcs  <= wdata_i[0];
          A_TEST:  m_q.test <= wdata_i;
          default: ;
        endcase
      end
      if (xfer_i) s_q <= m_q;
    end
  end

  assign master_o = m_q;
  assign slave_o  = s_q;
endmodule

// File: rtl/chan_rd_mux.sv
module chan_rd_mux
  import chan_ctrl_bank_pkg::*;
#(
  parameter int         NCH   = 4,
  parameter logic [7:0] ID    = 8'h02,
  parameter logic [2:0] GRADE = 3'b000
) (
  input  logic [AW-1:0]  addr_i,
  input  logic           lsb_i,
  input  logic [5:0]     idx_i,
  input  cfg_t [NCH-1:0] master_i,
  output logic [DW-1:0]  data_o
);
  cfg_t sel;
  logic hit;

  // lowest enabled channel wins: scan downward, last match sticks
  always_comb begin
    sel = '0;
    hit = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (idx_i[i]) begin
        sel = master_i[i];
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      A_PORT:  data_o = {1'b0, lsb_i, 1'b0, 1'b1, 1'b1, 1'b0, lsb_i, 1'b0};
      A_ID:    data_o = ID;
      A_GRADE: data_o = {1'b0, GRADE, 4'b0000};
      A_INDEX: data_o = {2'b00, idx_i};
      A_MODE:  data_o = hit ? {5'b0, sel.pwr} : '0;
      A_CLK:   data_o = hit ? {7'b0, sel.dcs} : '0;
      A_TEST:  data_o = hit ? sel.test : '0;
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/chan_ctrl_bank.sv
module chan_ctrl_bank
  import chan_ctrl_bank_pkg::*;
#(
  parameter int         NCH   = 4,
  parameter logic [7:0] ID    = 8'h02,
  parameter logic [2:0] GRADE = 3'b000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [7:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [7:0]       rdata_o,
  output logic             lsb_first_o,
  output logic [3*NCH-1:0] pwr_mode_o,
  output logic [NCH-1:0]   dcs_en_o,
  output logic [4*NCH-1:0] test_mode_o,
  output logic [NCH-1:0]   pn_short_rst_o,
  output logic [NCH-1:0]   pn_long_rst_o,
  output logic [2*NCH-1:0] user_test_o
);
  localparam logic [5:0] IDX_DEFAULT = 6'((1 << NCH) - 1);

  logic           lsb_q;
  logic [5:0]     idx_q;
  logic           srst;
  logic           xfer;
  logic           chan_wr;
  logic [DW-1:0]  rd_val;
  cfg_t [NCH-1:0] masters, slaves;
  logic [NCH-1:0] master_dcs;

  assign srst    = wr_i && (addr_i == A_PORT) && (wdata_i[5] || wdata_i[2]);
  assign xfer    = wr_i && (addr_i == A_XFER) && wdata_i[0];
  assign chan_wr = wr_i && is_chan_addr(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_q <= 1'b0;
      idx_q <= IDX_DEFAULT;
    end else if (srst) begin
      lsb_q <= 1'b0;
      idx_q <= IDX_DEFAULT;
    end else if (wr_i) begin
      if (addr_i == A_PORT)  lsb_q <= wdata_i[6] | wdata_i[1];
      if (addr_i == A_INDEX) idx_q <= wdata_i[5:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_shadow u_sh (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .srst_i  (srst),
      .wr_i    (chan_wr && idx_q[g]),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .xfer_i  (xfer),
      .master_o(masters[g]),
      .slave_o (slaves[g])
    );
    assign pwr_mode_o[3*g +: 3]  = slaves[g].pwr;
    assign dcs_en_o[g]           = slaves[g].dcs;
    assign test_mode_o[4*g +: 4] = slaves[g].test[3:0];
    assign pn_short_rst_o[g]     = slaves[g].test[4];
    assign pn_long_rst_o[g]      = slaves[g].test[5];
    assign user_test_o[2*g +: 2] = slaves[g].test[7:6];
    assign master_dcs[g]         = masters[g].dcs;
  end

  chan_rd_mux #(.NCH(NCH), .ID(ID), .GRADE(GRADE)) u_rd (
    .addr_i  (addr_i),
    .lsb_i   (lsb_q),
    .idx_i   (idx_q),
    .master_i(masters),
    .data_o  (rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_val;
  end

  assign lsb_first_o = lsb_q;
endmodule

// File: rtl/chan_ctrl_bank_chk.sv
module chan_ctrl_bank_chk #(
  parameter int NCH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       addr_i,
  input logic [7:0]       wdata_i,
  input logic             wr_i,
  input logic             rd_i,
  input logic [7:0]       rdata_o,
  input logic             lsb_first_o,
  input logic [3*NCH-1:0] pwr_mode_o,
  input logic [NCH-1:0]   dcs_en_o,
  input logic [4*NCH-1:0] test_mode_o,
  input logic [NCH-1:0]   master_dcs
);
  logic xfer_c, srst_c;
  assign xfer_c = wr_i && addr_i == 8'hFF && wdata_i[0];
  assign srst_c = wr_i && addr_i == 8'h00 && (wdata_i[5] || wdata_i[2]);

  // R6
  outputs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(xfer_c || srst_c) |-> ($stable(pwr_mode_o) && $stable(dcs_en_o) && $stable(test_mode_o)));

  // R7
  xfer_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(xfer_c) |-> dcs_en_o == $past(master_dcs));

  // R9
  soft_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(srst_c) |-> (pwr_mode_o == '0 && dcs_en_o == '1 && test_mode_o == '0 && !lsb_first_o));

  // R11
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));

  // R3
  id_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && addr_i == 8'h01) |-> rdata_o == 8'h02);
endmodule

bind chan_ctrl_bank chan_ctrl_bank_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/tb_chan_ctrl_bank.sv
module tb_chan_ctrl_bank;
  localparam int NCH = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       addr_i = '0, wdata_i = '0;
  logic             wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]       rdata_o;
  logic             lsb_first_o;
  logic [3*NCH-1:0] pwr_mode_o;
  logic [NCH-1:0]   dcs_en_o, pn_short_rst_o, pn_long_rst_o;
  logic [4*NCH-1:0] test_mode_o;
  logic [2*NCH-1:0] user_test_o;

  chan_ctrl_bank #(.NCH(NCH)) dut (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;

  // reference model
  logic [2:0] m_pwr [NCH], s_pwr [NCH];
  logic       m_dcs [NCH], s_dcs [NCH];
  logic [7:0] m_tst [NCH], s_tst [NCH];
  logic [5:0] idx;
  logic       lsb;

  task automatic model_defaults();
    for (int i = 0; i < NCH; i++) begin
      m_pwr[i] = 0; s_pwr[i] = 0; m_dcs[i] = 1; s_dcs[i] = 1; m_tst[i] = 0; s_tst[i] = 0;
    end
    idx = 6'h0F; lsb = 0;
  endtask

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    if (a == 8'h00) begin
      if (d[5] || d[2]) model_defaults();
      else lsb = d[6] | d[1];
    end else if (a == 8'h05) idx = d[5:0];
    else if (a == 8'hFF) begin
      if (d[0]) for (int i = 0; i < NCH; i++) begin
        s_pwr[i] = m_pwr[i]; s_dcs[i] = m_dcs[i]; s_tst[i] = m_tst[i];
      end
    end else for (int i = 0; i < NCH; i++) if (idx[i]) begin
      if (a == 8'h08) m_pwr[i] = d[2:0];
      if (a == 8'h09) m_dcs[i] = d[0];
      if (a == 8'h0D) m_tst[i] = d;
    end
  endtask

  function automatic logic [7:0] exp_read(logic [7:0] a);
    int c;
    c = -1;
    for (int i = NCH - 1; i >= 0; i--) if (idx[i]) c = i;
    case (a)
      8'h00: return lsb ? 8'h5A : 8'h18;
      8'h01: return 8'h02;
      8'h02: return 8'h00;
      8'h05: return {2'b00, idx};
      8'h08: return (c < 0) ? 8'h00 : {5'b0, m_pwr[c]};
      8'h09: return (c < 0) ? 8'h00 : {7'b0, m_dcs[c]};
      8'h0D: return (c < 0) ? 8'h00 : m_tst[c];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(string req);
    logic [3*NCH-1:0] ep; logic [NCH-1:0] ed, es, el; logic [4*NCH-1:0] et; logic [2*NCH-1:0] eu;
    for (int i = 0; i < NCH; i++) begin
      ep[3*i +: 3] = s_pwr[i]; ed[i] = s_dcs[i]; et[4*i +: 4] = s_tst[i][3:0];
      es[i] = s_tst[i][4]; el[i] = s_tst[i][5]; eu[2*i +: 2] = s_tst[i][7:6];
    end
    check({req, " pwr"}, 32'(pwr_mode_o), 32'(ep));
    check({req, " dcs"}, 32'(dcs_en_o), 32'(ed));
    check({req, " test"}, 32'(test_mode_o), 32'(et));
    check({req, " pn"}, 32'({pn_long_rst_o, pn_short_rst_o}), 32'({el, es}));
    check({req, " user"}, 32'(user_test_o), 32'(eu));
    check({req, " lsb"}, 32'(lsb_first_o), 32'(lsb));
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1;
    @(negedge clk_i); wr_i = 0;
    model_write(a, d);
  endtask

  task automatic rd(string req, logic [7:0] a);
    logic [7:0] held;
    @(negedge clk_i); held = rdata_o; addr_i = a; rd_i = 1;
    @(negedge clk_i); rd_i = 0;
    check(req, 32'(rdata_o), 32'(exp_read(a)));
    @(negedge clk_i);
    check("R11 hold", 32'(rdata_o), 32'(exp_read(a)));
    if (held === 8'hxx) check("R11 init", 32'(held), 32'(0));
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk_i);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  localparam logic [7:0] ADDRS [9] = '{8'h00, 8'h01, 8'h02, 8'h05, 8'h08, 8'h09, 8'h0D, 8'hFF, 8'h33};

  initial begin
    void'($urandom(32'd1234));
    model_defaults();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state
    check_outputs("R1");
    foreach (ADDRS[k]) rd("R1 reset read", ADDRS[k]);
    // R2 mirrored lsb bits
    wr(8'h00, 8'h40); rd("R2 bit6", 8'h00); check_outputs("R2");
    wr(8'h00, 8'h00); rd("R2 clear", 8'h00);
    wr(8'h00, 8'h02); rd("R2 bit1", 8'h00); check_outputs("R2");
    // R3 read-only
    wr(8'h01, 8'hFF); wr(8'h02, 8'hFF); rd("R3 id", 8'h01); rd("R3 grade", 8'h02);
    // R4 index with junk upper bits
    wr(8'h05, 8'hF5); rd("R4 index", 8'h05);
    // R5/R6 staged write to channels 0 and 2, masked bits
    wr(8'h08, 8'hFB); wr(8'h0D, 8'hA7); wr(8'h09, 8'hFE);
    check_outputs("R6 staged");
    rd("R5 mode mask", 8'h08); rd("R8 lowest", 8'h0D);
    // R7 transfer with bit0 clear: nothing
    wr(8'hFF, 8'hFE); check_outputs("R7 noop"); rd("R7 read", 8'hFF);
    wr(8'hFF, 8'h01); check_outputs("R7 xfer");
    // R8 sparse masks
    wr(8'h05, 8'h08); wr(8'h0D, 8'h3C); rd("R8 ch3", 8'h0D);
    wr(8'h05, 8'h0A); rd("R8 ch1", 8'h0D);
    wr(8'h05, 8'h00); rd("R8 none", 8'h0D); rd("R8 none dcs", 8'h09);
    wr(8'h0D, 8'h55); wr(8'h05, 8'h0F); rd("R5 none sel write", 8'h0D);
    // R10 unmapped
    wr(8'h33, 8'hFF); rd("R10 unmapped", 8'h33); check_outputs("R10");
    // R9 soft reset after staging via each mirrored bit
    wr(8'h08, 8'h02); wr(8'h00, 8'h20); check_outputs("R9 bit5");
    rd("R9 port", 8'h00); rd("R9 idx", 8'h05); rd("R9 mode", 8'h08);
    wr(8'h08, 8'h03); wr(8'hFF, 8'h01); wr(8'h00, 8'h04); check_outputs("R9 bit2");
    wr(8'hFF, 8'h01); check_outputs("R9 masters cleared");
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a, d;
      a = ADDRS[$urandom_range(8, 0)];
      d = 8'($urandom);
      if (a == 8'h00 && $urandom_range(9, 0) != 0) d = d & 8'hDB;
      if ($urandom_range(2, 0) == 0) rd("R8 random read", a);
      else begin
        wr(a, d);
        check_outputs("R5 random");
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule